// File: doc/BRIEF.md
# Interrupt exception entry and return sequencer

This block steps a processor core into and out of interrupt handling. When an interrupt request is accepted, it saves the running program counter, the status word and the stack-pointer general register into three shadow registers in one clock. In the same clock it raises the block, privilege and register-bank flags of the status word, records the source's exception code in an event register, and issues a one-cycle redirect to the handler entry at the vector base plus 0x600. A return command brings the status word back from its shadow and redirects to the saved program counter. The saved general register is never copied back to the core, so it remains available to software after the return.

The status word, the event register and the vector base are held inside the block. The core supplies the current program counter and general register 15, and it follows the redirect strobe. Privileged software loads the vector base and the three shadows through a synchronous write port. Reset makes the block issue a redirect to a fixed reset vector. Reset also leaves the status word with block, privilege and bank set and the floating-point-disable flag clear.

Top module: `irq_entry_seq`

## Requirements
- R1: On an accepted interrupt, spc_o, ssr_o and sgr_o take the values of cur_pc, sr_o and cur_gr15 from the accepting cycle, all at the following clock edge.
- R2: On an accepted interrupt, sr_o bits 28 (block), 29 (bank) and 30 (privilege) become 1. Bit 15 (floating-point disable) keeps its value, and the remaining bits are unchanged.
- R3: While reset is asserted, and in the first cycle after it is released, sr_o = 0x70000000 (bit 15 clear), vbr_o = 0, evt_o = 0, redir_valid = 1 and redir_addr = 0xA0000000. redir_valid drops at the first clock edge after release unless a return or an interrupt entry is taken at that edge.
- R4: On an accepted interrupt, evt_o[13:0] takes irq_code and evt_o[31:14] is 0.
- R5: An accepted interrupt makes redir_valid high for exactly one cycle, with redir_addr = vbr_o + 0x600 (modulo 2^32). redir_valid is low in any cycle that follows a cycle with neither an entry nor a return.
- R6: A return (ret_req high) makes sr_o equal the previous ssr_o and raises redir_valid for one cycle with redir_addr equal to the previous spc_o. sgr_o is left unchanged.
- R7: An interrupt request is ignored while sr_o bit 28 is 1: no redirect occurs, and spc_o, ssr_o, sgr_o, evt_o and sr_o do not change.
- R8: When ret_req and irq_req are high in the same cycle, the return is taken and the interrupt is dropped: evt_o and spc_o do not take the interrupt's values.
- R9: With wr_en high, sr_o bit 30 = 1 and no return or entry in that cycle, wr_data is written at the next edge to the register chosen by wr_sel: 0 = vbr_o, 1 = spc_o, 2 = ssr_o, 3 = sgr_o.
- R10: A write is ignored when sr_o bit 30 is 0, and also when a return or an entry is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request already arbitrated |
| irq_code | input | 14 | Exception code of the requesting source |
| ret_req | input | 1 | Return-from-exception command |
| cur_pc | input | 32 | Program counter of the current instruction |
| cur_gr15 | input | 32 | Current value of general register 15 |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target: 0 vector base, 1 saved PC, 2 saved status, 3 saved GR15 |
| wr_data | input | 32 | Software write data |
| sr_o | output | 32 | Status word |
| spc_o | output | 32 | Saved program counter |
| ssr_o | output | 32 | Saved status word |
| sgr_o | output | 32 | Saved general register 15 |
| vbr_o | output | 32 | Vector base |
| evt_o | output | 32 | Interrupt event code |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_addr | output | 32 | Redirect target address |

## Verification
The properties assume that every input is known in every cycle after reset is released and that the inputs change only between clock edges. They also assume that the core presents cur_pc and cur_gr15 in the cycle the request is raised, because the block samples them only at the accepting edge. The stimulus drives all inputs on the falling edge and never leaves one undriven. The random phase covers all four wr_sel codes and sets ret_req, irq_req and wr_en together in some cycles, so the priority and blocking rules are exercised as well.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   localparam int SR_FD = 15;
   localparam int SR_BL = 28;
   localparam int SR_RB = 29;
   localparam int SR_MD = 30;

   typedef enum logic [1:0] {
      SEL_VBR = 2'd0,
      SEL_SPC = 2'd1,
      SEL_SSR = 2'd2,
      SEL_SGR = 2'd3
   } wsel_e;

   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_ENTRY  = 2'd1,
      EV_RETURN = 2'd2,
      EV_WRITE  = 2'd3
   } event_e;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_entry_pkg::*;
(
   input  logic   irq_req,
   input  logic   ret_req,
   input  logic   wr_en,
   input  logic   blocked,
   input  logic   priv,
   output event_e ev
);
   // return outranks interrupt, which outranks a software write
   always_comb begin
      if (ret_req)
         ev = EV_RETURN;
      else if (irq_req && !blocked)
         ev = EV_ENTRY;
      else if (wr_en && priv)
         ev = EV_WRITE;
      else
         ev = EV_NONE;
   end
endmodule

// File: rtl/irq_entry_shadow.sv
module irq_entry_shadow
   import irq_entry_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  event_e          ev,
   input  logic [1:0]      wr_sel,
   input  logic [XLEN-1:0] wr_data,
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] cur_sr,
   input  logic [XLEN-1:0] cur_gr15,
   output logic [XLEN-1:0] spc,
   output logic [XLEN-1:0] ssr,
   output logic [XLEN-1:0] sgr,
   output logic [XLEN-1:0] vbr
);
   wsel_e sel;
   assign sel = wsel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spc <= '0;
         ssr <= '0;
         sgr <= '0;
         vbr <= '0;
      end else begin
         case (ev)
            EV_ENTRY: begin
               spc <= cur_pc;
               ssr <= cur_sr;
               sgr <= cur_gr15;
            end
            EV_WRITE: begin
               case (sel)
                  SEL_VBR: vbr <= wr_data;
                  SEL_SPC: spc <= wr_data;
                  SEL_SSR: ssr <= wr_data;
                  SEL_SGR: sgr <= wr_data;
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_status.sv
module irq_entry_status
   import irq_entry_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  event_e            ev,
   input  logic [XLEN-1:0]   ssr,
   input  logic [CODE_W-1:0] code,
   output logic [XLEN-1:0]   sr,
   output logic [XLEN-1:0]   evt
);
   localparam logic [XLEN-1:0] ENTRY_SET =
      (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_MD);
   // reset leaves the FPU-disable flag clear
   localparam logic [XLEN-1:0] SR_RESET = ENTRY_SET;

   logic [XLEN-1:0] code_ext;

   generate
      if (CODE_W == XLEN) begin : g_code_full
         assign code_ext = code;
      end else begin : g_code_pad
         assign code_ext = {{(XLEN-CODE_W){1'b0}}, code};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= SR_RESET;
         evt <= '0;
      end else begin
         case (ev)
            EV_ENTRY: begin
               sr  <= sr | ENTRY_SET;
               evt <= code_ext;
            end
            EV_RETURN: sr <= ssr;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_redirect.sv
module irq_entry_redirect
   import irq_entry_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] VEC_OFS   = 'h600,
   parameter logic [XLEN-1:0] RESET_VEC = 'hA000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  event_e          ev,
   input  logic [XLEN-1:0] vbr,
   input  logic [XLEN-1:0] spc,
   output logic            valid,
   output logic [XLEN-1:0] addr
);
   logic [XLEN-1:0] handler;

   generate
      if (VEC_OFS == '0) begin : g_no_ofs
         assign handler = vbr;
      end else begin : g_ofs
         assign handler = vbr + VEC_OFS;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b1;
         addr  <= RESET_VEC;
      end else begin
         valid <= 1'b0;
         case (ev)
            EV_ENTRY: begin
               valid <= 1'b1;
               addr  <= handler;
            end
            EV_RETURN: begin
               valid <= 1'b1;
               addr  <= spc;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              CODE_W    = 14,
   parameter logic [XLEN-1:0] VEC_OFS   = 'h600,
   parameter logic [XLEN-1:0] RESET_VEC = 'hA000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [CODE_W-1:0] irq_code,
   input  logic              ret_req,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   cur_gr15,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [XLEN-1:0]   wr_data,
   output logic [XLEN-1:0]   sr_o,
   output logic [XLEN-1:0]   spc_o,
   output logic [XLEN-1:0]   ssr_o,
   output logic [XLEN-1:0]   sgr_o,
   output logic [XLEN-1:0]   vbr_o,
   output logic [XLEN-1:0]   evt_o,
   output logic              redir_valid,
   output logic [XLEN-1:0]   redir_addr
);
   generate
      if (XLEN <= SR_MD) begin : g_bad_xlen
         initial $fatal(1, "XLEN too small for status flag positions");
      end
      if (CODE_W < 1 || CODE_W > XLEN) begin : g_bad_code
         initial $fatal(1, "CODE_W must lie in 1..XLEN");
      end
   endgenerate

   event_e ev;

   irq_entry_ctrl u_ctrl (
      .irq_req (irq_req),
      .ret_req (ret_req),
      .wr_en   (wr_en),
      .blocked (sr_o[SR_BL]),
      .priv    (sr_o[SR_MD]),
      .ev      (ev)
   );

   irq_entry_shadow #(.XLEN(XLEN)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .cur_pc   (cur_pc),
      .cur_sr   (sr_o),
      .cur_gr15 (cur_gr15),
      .spc      (spc_o),
      .ssr      (ssr_o),
      .sgr      (sgr_o),
      .vbr      (vbr_o)
   );

   irq_entry_status #(.XLEN(XLEN), .CODE_W(CODE_W)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .ssr   (ssr_o),
      .code  (irq_code),
      .sr    (sr_o),
      .evt   (evt_o)
   );

   irq_entry_redirect #(.XLEN(XLEN), .VEC_OFS(VEC_OFS), .RESET_VEC(RESET_VEC)) u_redir (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .vbr   (vbr_o),
      .spc   (spc_o),
      .valid (redir_valid),
      .addr  (redir_addr)
   );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
   import irq_entry_pkg::*;
#(
   parameter int              XLEN    = 32,
   parameter int              CODE_W  = 14,
   parameter logic [XLEN-1:0] VEC_OFS = 'h600
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [CODE_W-1:0] irq_code,
   input logic              ret_req,
   input logic [XLEN-1:0]   cur_pc,
   input logic [XLEN-1:0]   cur_gr15,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [XLEN-1:0]   wr_data,
   input logic [XLEN-1:0]   sr_o,
   input logic [XLEN-1:0]   spc_o,
   input logic [XLEN-1:0]   ssr_o,
   input logic [XLEN-1:0]   sgr_o,
   input logic [XLEN-1:0]   vbr_o,
   input logic [XLEN-1:0]   evt_o,
   input logic              redir_valid,
   input logic [XLEN-1:0]   redir_addr
);
   logic entry_w;
   logic swr_w;
   assign entry_w = irq_req && !ret_req && !sr_o[SR_BL];
   assign swr_w   = wr_en && sr_o[SR_MD] && !ret_req && !entry_w;

   p_save_r1: assert property (@(posedge clk) disable iff (!rst_n)
      entry_w |=> spc_o == $past(cur_pc) && ssr_o == $past(sr_o) && sgr_o == $past(cur_gr15));

   p_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      entry_w |=> sr_o[SR_BL] && sr_o[SR_MD] && sr_o[SR_RB] && sr_o[SR_FD] == $past(sr_o[SR_FD]));

   p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      entry_w |=> evt_o == XLEN'($past(irq_code)));

   p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      entry_w |=> redir_valid && redir_addr == $past(vbr_o) + VEC_OFS);

   p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_req && !entry_w) |=> !redir_valid);

   p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ret_req |=> redir_valid && sr_o == $past(ssr_o) && redir_addr == $past(spc_o) && $stable(sgr_o));

   p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && sr_o[SR_BL] && !ret_req && !wr_en) |=>
         !redir_valid && $stable(spc_o) && $stable(ssr_o) && $stable(sgr_o) && $stable(evt_o) && $stable(sr_o));

   p_retwins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && irq_req) |=> $stable(evt_o) && $stable(spc_o));

   p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      swr_w |=> ($past(wr_sel) != 2'd0 || vbr_o == $past(wr_data))
             && ($past(wr_sel) != 2'd1 || spc_o == $past(wr_data))
             && ($past(wr_sel) != 2'd2 || ssr_o == $past(wr_data))
             && ($past(wr_sel) != 2'd3 || sgr_o == $past(wr_data)));

   p_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sr_o[SR_MD] && !ret_req && !entry_w) |=>
         $stable(vbr_o) && $stable(spc_o) && $stable(ssr_o) && $stable(sgr_o));
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W), .VEC_OFS(VEC_OFS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_req     (irq_req),
   .irq_code    (irq_code),
   .ret_req     (ret_req),
   .cur_pc      (cur_pc),
   .cur_gr15    (cur_gr15),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .sr_o        (sr_o),
   .spc_o       (spc_o),
   .ssr_o       (ssr_o),
   .sgr_o       (sgr_o),
   .vbr_o       (vbr_o),
   .evt_o       (evt_o),
   .redir_valid (redir_valid),
   .redir_addr  (redir_addr)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [13:0] irq_code = '0;
   logic        ret_req = 1'b0;
   logic [31:0] cur_pc = '0;
   logic [31:0] cur_gr15 = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] sr_o, spc_o, ssr_o, sgr_o, vbr_o, evt_o, redir_addr;
   logic        redir_valid;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_entry_seq dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_code(irq_code),
      .ret_req(ret_req), .cur_pc(cur_pc), .cur_gr15(cur_gr15), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .sr_o(sr_o), .spc_o(spc_o),
      .ssr_o(ssr_o), .sgr_o(sgr_o), .vbr_o(vbr_o), .evt_o(evt_o),
      .redir_valid(redir_valid), .redir_addr(redir_addr)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   // behavioural reference model, stepped at every rising edge
   logic [31:0] m_sr, m_spc, m_ssr, m_sgr, m_vbr, m_evt, m_ra;
   logic        m_rv;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sr <= 32'h7000_0000; m_spc <= 0; m_ssr <= 0; m_sgr <= 0;
         m_vbr <= 0; m_evt <= 0; m_rv <= 1'b1; m_ra <= 32'hA000_0000;
      end else begin
         m_rv <= 1'b0;
         if (ret_req) begin
            m_sr <= m_ssr; m_ra <= m_spc; m_rv <= 1'b1;
         end else if (irq_req && m_sr[28] == 1'b0) begin
            m_spc <= cur_pc; m_ssr <= m_sr; m_sgr <= cur_gr15;
            m_sr <= m_sr | 32'h7000_0000;
            m_evt <= {18'd0, irq_code};
            m_ra <= m_vbr + 32'h600; m_rv <= 1'b1;
         end else if (wr_en && m_sr[30]) begin
            if (wr_sel == 0) m_vbr <= wr_data;
            if (wr_sel == 1) m_spc <= wr_data;
            if (wr_sel == 2) m_ssr <= wr_data;
            if (wr_sel == 3) m_sgr <= wr_data;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         eq("R1 model spc", spc_o, m_spc);
         eq("R1 model ssr", ssr_o, m_ssr);
         eq("R6 model sgr", sgr_o, m_sgr);
         eq("R2 model sr", sr_o, m_sr);
         eq("R9 model vbr", vbr_o, m_vbr);
         eq("R4 model evt", evt_o, m_evt);
         eq("R5 model valid", {31'd0, redir_valid}, {31'd0, m_rv});
         if (m_rv) eq("R5 model addr", redir_addr, m_ra);
      end
   end

   task automatic idle();
      irq_req = 0; ret_req = 0; wr_en = 0;
   endtask

   // drive one cycle of stimulus from a falling edge; returns at the next falling edge
   task automatic op(input bit irq, input logic [13:0] code, input bit ret,
                     input logic [31:0] pc, input logic [31:0] gr,
                     input bit we, input logic [1:0] sel, input logic [31:0] data);
      irq_req = irq; irq_code = code; ret_req = ret; cur_pc = pc; cur_gr15 = gr;
      wr_en = we; wr_sel = sel; wr_data = data;
      @(negedge clk);
      idle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      eq("R3 reset sr", sr_o, 32'h7000_0000);
      eq("R3 reset vbr", vbr_o, 32'h0);
      eq("R3 reset evt", evt_o, 32'h0);
      eq("R3 reset valid", {31'd0, redir_valid}, 32'd1);
      eq("R3 reset vector", redir_addr, 32'hA000_0000);
      @(negedge clk);
      eq("R3 strobe drops", {31'd0, redir_valid}, 32'd0);

      op(0, 0, 0, 0, 0, 1, 2'd0, 32'h8000_0000);
      eq("R9 write vbr", vbr_o, 32'h8000_0000);
      op(0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_1000);
      op(0, 0, 0, 0, 0, 1, 2'd2, 32'h0000_8000);
      op(0, 0, 0, 0, 0, 1, 2'd3, 32'h0000_0055);
      eq("R9 write spc", spc_o, 32'h1000);
      eq("R9 write ssr", ssr_o, 32'h8000);
      eq("R9 write sgr", sgr_o, 32'h55);

      op(1, 14'h5, 0, 32'h9999, 32'h7777, 0, 0, 0);
      eq("R7 blocked valid", {31'd0, redir_valid}, 32'd0);
      eq("R7 blocked evt", evt_o, 32'h0);
      eq("R7 blocked spc", spc_o, 32'h1000);

      op(0, 0, 1, 0, 0, 0, 0, 0);
      eq("R6 return sr", sr_o, 32'h0000_8000);
      eq("R6 return addr", redir_addr, 32'h1000);
      eq("R6 return valid", {31'd0, redir_valid}, 32'd1);
      eq("R6 sgr kept", sgr_o, 32'h55);

      op(0, 0, 0, 0, 0, 1, 2'd0, 32'h1234);
      eq("R10 user write ignored", vbr_o, 32'h8000_0000);

      op(1, 14'h3FFF, 0, 32'h2000, 32'hAAAA, 0, 0, 0);
      eq("R1 spc", spc_o, 32'h2000);
      eq("R1 ssr", ssr_o, 32'h8000);
      eq("R1 sgr", sgr_o, 32'hAAAA);
      eq("R2 sr keeps FD", sr_o, 32'h7000_8000);
      eq("R4 evt", evt_o, 32'h3FFF);
      eq("R5 vector", redir_addr, 32'h8000_0600);
      eq("R5 valid", {31'd0, redir_valid}, 32'd1);
      @(negedge clk);
      eq("R5 one cycle", {31'd0, redir_valid}, 32'd0);

      op(0, 0, 0, 0, 0, 1, 2'd2, 32'h4000_0000);
      op(0, 0, 0, 0, 0, 1, 2'd1, 32'h3000);
      op(1, 14'h11, 1, 32'h4444, 32'h1, 0, 0, 0);
      eq("R8 sr", sr_o, 32'h4000_0000);
      eq("R8 addr", redir_addr, 32'h3000);
      eq("R8 evt kept", evt_o, 32'h3FFF);
      eq("R8 spc kept", spc_o, 32'h3000);
      eq("R6 sgr after return", sgr_o, 32'hAAAA);

      op(1, 14'h0123, 0, 32'h5000, 32'h6, 1, 2'd0, 32'h0);
      eq("R10 write lost to entry", vbr_o, 32'h8000_0000);
      eq("R2 sr FD clear", sr_o, 32'h7000_0000);
      eq("R4 evt small", evt_o, 32'h0123);
      eq("R5 vector again", redir_addr, 32'h8000_0600);

      for (int i = 0; i < 400; i++) begin
         op($urandom_range(0, 3) == 0, 14'($urandom), $urandom_range(0, 5) == 0,
            $urandom, $urandom, $urandom_range(0, 1) == 1, 2'($urandom), $urandom);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule